// File: doc/BRIEF.md
# Fully Associative Translation Buffer

This block caches virtual-to-physical page mappings in a small, fully associative array. Each slot holds a virtual page base, a physical page base, the log2 of its page size, a global flag and an uncacheable flag. Pages of different sizes can live in the array at the same time. A slot matches an address when the two agree on every bit above that slot's page-size boundary. The translated address is the physical base ORed with the untranslated low bits of the address.

Lookups are combinational. A lookup can optionally mark the slot it hits as recently used. Inserts, single-page demaps, a full flush and a flush that keeps global mappings all take effect on the next rising clock edge.

Replacement uses age stamps. A 32-bit counter, cleared at reset, supplies a new stamp to every freshly written slot and to every slot refreshed by a lookup. When no slot is free, the slot with the smallest stamp is overwritten.

Top module: `xlate_buffer`

## Requirements
- R1: After reset every slot is invalid: no lookup address hits, `insExisting` is 0 and `insIdx` is 0.
- R2: Slot i matches address A when it is valid and `A >> log_i` equals `vbase_i >> log_i`. On a hit, `lkPaddr` equals `pbase + (A mod 2^log)` (bases are page aligned) and `lkUncache` equals the slot's uncacheable flag. When several slots match, `lkIdx` names the lowest-numbered one. On a miss, `lkHit`, `lkPaddr` and `lkUncache` are 0.
- R3: An insert whose base hits no valid slot writes the lowest-numbered invalid slot at the next edge. `insIdx` shows that slot during the cycle before the edge and `insExisting` is 0.
- R4: An insert whose base already hits a valid slot writes nothing. During that cycle `insExisting` is 1 and `insIdx` names the slot that was hit; the mapping that slot holds is unchanged afterwards.
- R5: When every slot is valid, an insert overwrites the slot with the smallest stamp. A tie goes to the lowest index.
- R6: The stamp counter starts at 0. Each write of a new slot and each refresh gives that slot the counter value plus one and advances the counter. A lookup refreshes its hit slot only when `lkTouch` is 1; with `lkTouch` at 0 the slot's stamp is unchanged.
- R7: A demap invalidates every slot matching `demapVaddr` and changes no stamp.
- R8: `flushNonGlobal` invalidates exactly the valid slots whose global flag is 0.
- R9: `flushAll` invalidates every slot.
- R10: At most one operation acts per cycle, in this priority order: `flushAll`, `flushNonGlobal`, demap, insert, lookup refresh. An insert presented together with a higher-priority operation is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lkVaddr | input | ADDR_W | Lookup address |
| lkTouch | input | 1 | Refresh the hit slot's stamp |
| lkHit | output | 1 | Lookup hit |
| lkIdx | output | IDX_W | Lowest matching slot |
| lkPaddr | output | ADDR_W | Translated address |
| lkUncache | output | 1 | Uncacheable flag of the hit slot |
| insValid | input | 1 | Insert request |
| insVbase | input | ADDR_W | Virtual page base to insert |
| insPbase | input | ADDR_W | Physical page base to insert |
| insLog | input | LOG_W | log2 page size to insert |
| insGlobal | input | 1 | Global flag to insert |
| insUncache | input | 1 | Uncacheable flag to insert |
| insExisting | output | 1 | Insert base already hits a slot |
| insIdx | output | IDX_W | Slot the insert uses or found |
| demapValid | input | 1 | Demap request |
| demapVaddr | input | ADDR_W | Address to demap |
| flushAll | input | 1 | Invalidate all slots |
| flushNonGlobal | input | 1 | Invalidate non-global slots |

## Verification
The hardest case to reach is eviction whose outcome depends on a refresh that happened several cycles earlier. The stamps cannot be observed at the ports, so the bench fills the array, refreshes one slot with `lkTouch`, and does a plain lookup of another slot with `lkTouch` at 0. It then inserts twice into the full array and checks `insIdx` against the victim that the stamp history predicts. A second hard case is an overlap between a large page and a smaller page held in a higher-numbered slot. Such an overlap can only arise when the larger page is inserted later, at a base outside the small one. The bench builds it that way and then sweeps every address of the small configuration against its own model after each phase.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  // One-hot set of state-changing actions chosen by the control for this cycle.
  typedef struct packed {
    logic write;
    logic touch;
    logic demap;
    logic flushAll;
    logic flushNg;
  } xlateStrobe_t;
endpackage

// File: rtl/xlate_match.sv
module xlate_match #(
  parameter int N      = 8,
  parameter int ADDR_W = 32,
  parameter int LOG_W  = 5,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] entVbase [N],
  input  logic [LOG_W-1:0]  entLog   [N],
  input  logic [N-1:0]      validVec,
  output logic [N-1:0]      hitVec,
  output logic              anyHit,
  output logic [IDX_W-1:0]  firstIdx
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    logic [ADDR_W-1:0] keepMask;
    assign keepMask  = ~((ADDR_W'(1) << entLog[i]) - ADDR_W'(1));
    assign hitVec[i] = validVec[i] && (((addr ^ entVbase[i]) & keepMask) == '0);
  end

  assign anyHit = |hitVec;

  always_comb begin
    firstIdx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hitVec[i]) firstIdx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
#(
  parameter int N       = 8,
  parameter int STAMP_W = 32,
  localparam int IDX_W  = (N > 1) ? $clog2(N) : 1
) (
  input  logic               flushAll,
  input  logic               flushNonGlobal,
  input  logic               demapValid,
  input  logic               insValid,
  input  logic               insHit,
  input  logic [IDX_W-1:0]   insHitIdx,
  input  logic               lkTouch,
  input  logic               lkHit,
  input  logic [N-1:0]       validVec,
  input  logic [STAMP_W-1:0] stamps [N],
  output xlateStrobe_t       strobe,
  output logic [IDX_W-1:0]   tgtIdx,
  output logic               insExisting
);
  logic             freeFound;
  logic [IDX_W-1:0] freeIdx;
  logic [IDX_W-1:0] lruIdx;
  logic [STAMP_W-1:0] lruStamp;
  logic             maintBusy;

  // Lowest-numbered free slot.
  always_comb begin
    freeFound = 1'b0;
    freeIdx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!validVec[i]) begin
        freeFound = 1'b1;
        freeIdx   = IDX_W'(i);
      end
    end
  end

  // Oldest slot; strict compare keeps the lowest index on ties.
  always_comb begin
    lruIdx   = '0;
    lruStamp = stamps[0];
    for (int i = 1; i < N; i++) begin
      if (stamps[i] < lruStamp) begin
        lruIdx   = IDX_W'(i);
        lruStamp = stamps[i];
      end
    end
  end

  assign insExisting = insHit;
  assign tgtIdx      = insHit ? insHitIdx : (freeFound ? freeIdx : lruIdx);
  assign maintBusy   = flushAll || flushNonGlobal || demapValid;

  always_comb begin
    strobe          = '0;
    strobe.flushAll = flushAll;
    strobe.flushNg  = !flushAll && flushNonGlobal;
    strobe.demap    = !flushAll && !flushNonGlobal && demapValid;
    strobe.write    = !maintBusy && insValid && !insHit;
    strobe.touch    = !maintBusy && !insValid && lkTouch && lkHit;
  end
endmodule

// File: rtl/xlate_store.sv
module xlate_store
  import xlate_pkg::*;
#(
  parameter int N       = 8,
  parameter int ADDR_W  = 32,
  parameter int LOG_W   = 5,
  parameter int STAMP_W = 32,
  localparam int IDX_W  = (N > 1) ? $clog2(N) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  xlateStrobe_t       strobe,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic [IDX_W-1:0]   touchIdx,
  input  logic [N-1:0]       demapHits,
  input  logic [ADDR_W-1:0]  wrVbase,
  input  logic [ADDR_W-1:0]  wrPbase,
  input  logic [LOG_W-1:0]   wrLog,
  input  logic               wrGlobal,
  input  logic               wrUncache,
  input  logic [IDX_W-1:0]   rdIdx,
  input  logic [ADDR_W-1:0]  rdVaddr,
  output logic [ADDR_W-1:0]  rdPaddr,
  output logic               rdUncache,
  output logic [N-1:0]       validVec,
  output logic [N-1:0]       globalVec,
  output logic [ADDR_W-1:0]  vbaseArr [N],
  output logic [LOG_W-1:0]   logArr   [N],
  output logic [STAMP_W-1:0] stampArr [N],
  output logic [STAMP_W-1:0] stampCnt
);
  logic [ADDR_W-1:0]  pbaseQ [N];
  logic [N-1:0]       uncacheQ;
  logic [STAMP_W-1:0] nextStamp;
  logic [ADDR_W-1:0]  lowMask;

  assign nextStamp = stampCnt + STAMP_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validVec  <= '0;
      globalVec <= '0;
      uncacheQ  <= '0;
      stampCnt  <= '0;
      for (int i = 0; i < N; i++) begin
        vbaseArr[i] <= '0;
        pbaseQ[i]   <= '0;
        logArr[i]   <= '0;
        stampArr[i] <= '0;
      end
    end else begin
      if (strobe.flushAll) begin
        validVec <= '0;
      end else if (strobe.flushNg) begin
        validVec <= validVec & globalVec;
      end else if (strobe.demap) begin
        validVec <= validVec & ~demapHits;
      end else if (strobe.write) begin
        validVec[wrIdx]  <= 1'b1;
        vbaseArr[wrIdx]  <= wrVbase;
        pbaseQ[wrIdx]    <= wrPbase;
        logArr[wrIdx]    <= wrLog;
        globalVec[wrIdx] <= wrGlobal;
        uncacheQ[wrIdx]  <= wrUncache;
        stampArr[wrIdx]  <= nextStamp;
        stampCnt         <= nextStamp;
      end else if (strobe.touch) begin
        stampArr[touchIdx] <= nextStamp;
        stampCnt           <= nextStamp;
      end
    end
  end

  assign lowMask   = (ADDR_W'(1) << logArr[rdIdx]) - ADDR_W'(1);
  assign rdPaddr   = pbaseQ[rdIdx] | (rdVaddr & lowMask);
  assign rdUncache = uncacheQ[rdIdx];
endmodule

// File: rtl/xlate_buffer.sv
module xlate_buffer
  import xlate_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int ADDR_W      = 32,
  parameter int LOG_W       = 5,
  parameter int STAMP_W     = 32,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] lkVaddr,
  input  logic              lkTouch,
  output logic              lkHit,
  output logic [IDX_W-1:0]  lkIdx,
  output logic [ADDR_W-1:0] lkPaddr,
  output logic              lkUncache,
  input  logic              insValid,
  input  logic [ADDR_W-1:0] insVbase,
  input  logic [ADDR_W-1:0] insPbase,
  input  logic [LOG_W-1:0]  insLog,
  input  logic              insGlobal,
  input  logic              insUncache,
  output logic              insExisting,
  output logic [IDX_W-1:0]  insIdx,
  input  logic              demapValid,
  input  logic [ADDR_W-1:0] demapVaddr,
  input  logic              flushAll,
  input  logic              flushNonGlobal
);
  if (NUM_ENTRIES < 1) begin : g_bad_size
    $error("xlate_buffer: NUM_ENTRIES must be at least 1");
  end

  xlateStrobe_t       strobe;
  logic [NUM_ENTRIES-1:0] validVec;
  logic [NUM_ENTRIES-1:0] globalVec;
  logic [ADDR_W-1:0]  vbaseArr [NUM_ENTRIES];
  logic [LOG_W-1:0]   logArr   [NUM_ENTRIES];
  logic [STAMP_W-1:0] stampArr [NUM_ENTRIES];
  logic [STAMP_W-1:0] stampCnt;

  logic [NUM_ENTRIES-1:0] lkHits, insHits, demapHits;
  logic               lkAny, insAny, demapAny;
  logic [IDX_W-1:0]   lkFirst, insFirst, demapFirst;
  logic [ADDR_W-1:0]  rdPaddr;
  logic               rdUncache;

  xlate_match #(.N(NUM_ENTRIES), .ADDR_W(ADDR_W), .LOG_W(LOG_W)) u_lkMatch (
    .addr(lkVaddr), .entVbase(vbaseArr), .entLog(logArr), .validVec(validVec),
    .hitVec(lkHits), .anyHit(lkAny), .firstIdx(lkFirst));

  xlate_match #(.N(NUM_ENTRIES), .ADDR_W(ADDR_W), .LOG_W(LOG_W)) u_insMatch (
    .addr(insVbase), .entVbase(vbaseArr), .entLog(logArr), .validVec(validVec),
    .hitVec(insHits), .anyHit(insAny), .firstIdx(insFirst));

  xlate_match #(.N(NUM_ENTRIES), .ADDR_W(ADDR_W), .LOG_W(LOG_W)) u_dmMatch (
    .addr(demapVaddr), .entVbase(vbaseArr), .entLog(logArr), .validVec(validVec),
    .hitVec(demapHits), .anyHit(demapAny), .firstIdx(demapFirst));

  xlate_ctrl #(.N(NUM_ENTRIES), .STAMP_W(STAMP_W)) u_ctrl (
    .flushAll(flushAll), .flushNonGlobal(flushNonGlobal), .demapValid(demapValid),
    .insValid(insValid), .insHit(insAny), .insHitIdx(insFirst),
    .lkTouch(lkTouch), .lkHit(lkAny), .validVec(validVec), .stamps(stampArr),
    .strobe(strobe), .tgtIdx(insIdx), .insExisting(insExisting));

  xlate_store #(.N(NUM_ENTRIES), .ADDR_W(ADDR_W), .LOG_W(LOG_W), .STAMP_W(STAMP_W)) u_store (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrIdx(insIdx), .touchIdx(lkFirst),
    .demapHits(demapHits), .wrVbase(insVbase), .wrPbase(insPbase), .wrLog(insLog),
    .wrGlobal(insGlobal), .wrUncache(insUncache), .rdIdx(lkFirst), .rdVaddr(lkVaddr),
    .rdPaddr(rdPaddr), .rdUncache(rdUncache), .validVec(validVec), .globalVec(globalVec),
    .vbaseArr(vbaseArr), .logArr(logArr), .stampArr(stampArr), .stampCnt(stampCnt));

  assign lkHit     = lkAny;
  assign lkIdx     = lkFirst;
  assign lkPaddr   = lkAny ? rdPaddr : '0;
  assign lkUncache = lkAny && rdUncache;

  logic unusedSig;
  assign unusedSig = demapAny ^ (|demapFirst);
endmodule

// File: rtl/xlate_buffer_chk.sv
module xlate_buffer_chk
  import xlate_pkg::*;
#(
  parameter int N       = 8,
  parameter int STAMP_W = 32
) (
  input logic               clk,
  input logic               rstN,
  input xlateStrobe_t       strobe,
  input logic               flushAll,
  input logic               flushNonGlobal,
  input logic               demapValid,
  input logic               insValid,
  input logic               insExisting,
  input logic [N-1:0]       validVec,
  input logic [N-1:0]       globalVec,
  input logic [N-1:0]       demapHits,
  input logic [STAMP_W-1:0] stampCnt
);
  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  p_one_action_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));

  p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rstN || !armed)
    flushAll |=> validVec == '0);

  p_keep_global_r8: assert property (@(posedge clk) disable iff (!rstN || !armed)
    (flushNonGlobal && !flushAll) |=> validVec == $past(validVec & globalVec));

  p_demap_clear_r7: assert property (@(posedge clk) disable iff (!rstN || !armed)
    (demapValid && !flushAll && !flushNonGlobal) |=> validVec == $past(validVec & ~demapHits));

  p_existing_nowrite_r4: assert property (@(posedge clk) disable iff (!rstN || !armed)
    (insValid && insExisting && !flushAll && !flushNonGlobal && !demapValid)
      |=> validVec == $past(validVec));

  p_stamp_step_r6: assert property (@(posedge clk) disable iff (!rstN || !armed)
    (strobe.write || strobe.touch) |=> stampCnt == $past(stampCnt) + STAMP_W'(1));

  p_stamp_hold_r6: assert property (@(posedge clk) disable iff (!rstN || !armed)
    !(strobe.write || strobe.touch) |=> $stable(stampCnt));
endmodule

bind xlate_buffer xlate_buffer_chk #(.N(NUM_ENTRIES), .STAMP_W(STAMP_W)) u_chk (
  .clk(clk), .rstN(rstN), .strobe(strobe), .flushAll(flushAll),
  .flushNonGlobal(flushNonGlobal), .demapValid(demapValid), .insValid(insValid),
  .insExisting(insExisting), .validVec(validVec), .globalVec(globalVec),
  .demapHits(demapHits), .stampCnt(stampCnt));

// File: tb/sim_xlate_buffer.sv
module sim_xlate_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int AW = 16;
  localparam int LW = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [AW-1:0] lkVaddr = '0;
  logic lkTouch = 1'b0;
  logic lkHit, lkUncache, insExisting;
  logic [IW-1:0] lkIdx, insIdx;
  logic [AW-1:0] lkPaddr;
  logic insValid = 1'b0;
  logic [AW-1:0] insVbase = '0, insPbase = '0;
  logic [LW-1:0] insLog = '0;
  logic insGlobal = 1'b0, insUncache = 1'b0;
  logic demapValid = 1'b0;
  logic [AW-1:0] demapVaddr = '0;
  logic flushAll = 1'b0, flushNonGlobal = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Bench model of slot contents (placement chosen by hand from the requirements).
  bit          mVal [N];
  int unsigned mVb  [N];
  int unsigned mPb  [N];
  int unsigned mLg  [N];
  bit          mGl  [N];
  bit          mUc  [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  xlate_buffer #(.NUM_ENTRIES(N), .ADDR_W(AW), .LOG_W(LW), .STAMP_W(32)) u0 (
    .clk(clk), .rstN(rstN), .lkVaddr(lkVaddr), .lkTouch(lkTouch), .lkHit(lkHit),
    .lkIdx(lkIdx), .lkPaddr(lkPaddr), .lkUncache(lkUncache), .insValid(insValid),
    .insVbase(insVbase), .insPbase(insPbase), .insLog(insLog), .insGlobal(insGlobal),
    .insUncache(insUncache), .insExisting(insExisting), .insIdx(insIdx),
    .demapValid(demapValid), .demapVaddr(demapVaddr), .flushAll(flushAll),
    .flushNonGlobal(flushNonGlobal));

  task automatic check(input string tag, input int unsigned got, input int unsigned exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic mSet(input int i, input int unsigned vb, input int unsigned pb,
                      input int unsigned lg, input bit g, input bit u);
    mVal[i] = 1'b1; mVb[i] = vb; mPb[i] = pb; mLg[i] = lg; mGl[i] = g; mUc[i] = u;
  endtask

  // R2: compare every address against the model.
  task automatic sweep(input string phase);
    for (int a = 0; a < 65536; a++) begin
      int expIdx;
      expIdx = -1;
      lkVaddr = AW'(a);
      for (int j = N - 1; j >= 0; j--) begin
        if (mVal[j] && ((a >> mLg[j]) == (mVb[j] >> mLg[j]))) expIdx = j;
      end
      #1;
      if (expIdx < 0) begin
        check({"R2 miss ", phase}, {lkHit, lkUncache, 16'(lkPaddr)}, 0);
      end else begin
        check({"R2 idx ", phase}, {lkHit, 2'(lkIdx)}, {1'b1, 2'(expIdx)});
        check({"R2 paddr ", phase}, lkPaddr,
              mPb[expIdx] + (a % (1 << mLg[expIdx])));
        check({"R2 uncache ", phase}, lkUncache, mUc[expIdx]);
      end
    end
  endtask

  // Drives an insert for one cycle; checks the reported slot before the edge.
  task automatic doInsert(input string tag, input int unsigned vb, input int unsigned pb,
                          input int unsigned lg, input bit g, input bit u,
                          input int expIdx, input bit expExist);
    insValid = 1'b1; insVbase = AW'(vb); insPbase = AW'(pb); insLog = LW'(lg);
    insGlobal = g; insUncache = u;
    #1;
    check({tag, " insExisting"}, insExisting, expExist);
    check({tag, " insIdx"}, insIdx, expIdx);
    @(posedge clk); #1;
    insValid = 1'b0;
    if (!expExist) mSet(expIdx, vb, pb, lg, g, u);
  endtask

  task automatic lookOne(input string tag, input int unsigned a, input bit expHit,
                         input int expIdx, input int unsigned expPa);
    lkVaddr = AW'(a);
    #1;
    check({tag, " hit"}, lkHit, expHit);
    if (expHit) begin
      check({tag, " idx"}, lkIdx, expIdx);
      check({tag, " paddr"}, lkPaddr, expPa);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < N; i++) mVal[i] = 1'b0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(posedge clk); #1;

    // R1: empty after reset.
    insVbase = 16'h1234; #1;
    check("R1 insExisting", insExisting, 0);
    check("R1 insIdx", insIdx, 0);
    sweep("reset R1");

    // R3: fill free slots lowest first (stamps 1..4).
    doInsert("R3 fill0", 16'h1000, 16'h8000, 12, 0, 0, 0, 0);
    doInsert("R3 fill1", 16'h2000, 16'h0300, 8, 0, 0, 1, 0);
    doInsert("R3 fill2", 16'h4000, 16'hC000, 14, 0, 0, 2, 0);
    doInsert("R3 fill3", 16'h0010, 16'h0A00, 4, 1, 1, 3, 0);
    sweep("filled R2");

    // R4: base already mapped, nothing written.
    doInsert("R4 dup", 16'h1000, 16'h9000, 12, 0, 0, 0, 1);
    lookOne("R4 dup kept", 16'h1234, 1, 0, 16'h8234);

    // R6: refresh slot 0 (stamp 5); plain lookup of slot 1 keeps stamp 2.
    lkVaddr = 16'h1ABC; lkTouch = 1'b1;
    @(posedge clk); #1;
    lkTouch = 1'b0; lkVaddr = 16'h2010;
    @(posedge clk); #1;

    // R5: victim is slot 1 (stamp 2).
    doInsert("R5 evict", 16'h9000, 16'h1000, 12, 0, 0, 1, 0);
    lookOne("R5 old gone", 16'h2000, 0, 0, 0);
    lookOne("R5 new hit", 16'h9123, 1, 1, 16'h1123);
    // R6: slot 0 was refreshed, so slot 2 (stamp 3) goes next.
    doInsert("R6 refreshed", 16'hA000, 16'h2000, 12, 0, 0, 2, 0);

    // R10: demap with insert in the same cycle; insert dropped. R7 demap of slot 3.
    demapValid = 1'b1; demapVaddr = 16'h0018;
    insValid = 1'b1; insVbase = 16'hB000; insPbase = 16'h7000; insLog = 12;
    @(posedge clk); #1;
    demapValid = 1'b0; insValid = 1'b0;
    mVal[3] = 1'b0;
    lookOne("R10 insert dropped", 16'hB000, 0, 0, 0);
    lookOne("R7 demapped", 16'h0018, 0, 0, 0);

    // R7/R3: freed slot is reused before any eviction.
    doInsert("R7 reuse free", 16'h0040, 16'h5040, 4, 1, 0, 3, 0);
    // R5: full again; slot 0 (stamp 5) is oldest.
    doInsert("R5 evict2", 16'hC000, 16'h3300, 8, 0, 1, 0, 0);

    // Overlap: free slot 1, then a 4 KiB page covering slot 3's small page.
    demapValid = 1'b1; demapVaddr = 16'h9FFF;
    @(posedge clk); #1;
    demapValid = 1'b0;
    mVal[1] = 1'b0;
    doInsert("R3 big page", 16'h0000, 16'h6000, 12, 0, 0, 1, 0);
    lookOne("R2 overlap lowest", 16'h0045, 1, 1, 16'h6045);
    sweep("overlap R2");

    // R8: only the global slot 3 remains.
    flushNonGlobal = 1'b1;
    @(posedge clk); #1;
    flushNonGlobal = 1'b0;
    for (int i = 0; i < N; i++) if (!mGl[i]) mVal[i] = 1'b0;
    lookOne("R8 global kept", 16'h0045, 1, 3, 16'h5045);
    sweep("flushNg R8");

    // R9: everything gone.
    flushAll = 1'b1;
    @(posedge clk); #1;
    flushAll = 1'b0;
    for (int i = 0; i < N; i++) mVal[i] = 1'b0;
    sweep("flushAll R9");

    summary();
  end
endmodule